// File: doc/BRIEF.md
# SPI Controller Status Interrupt Unit

This unit watches thirteen live condition flags coming from an SPI controller's FIFOs and transfer engine. It turns each low-to-high transition of a flag into a sticky cause bit and drives a single interrupt line from the cause bits that software has enabled. Causes respond to edges, not levels. A flag that is already high when software enables its mask bit raises no interrupt, so the driver must read the live status view before it waits.

Software reaches the unit through a small register port. A 2-bit select picks the live status view, the cause register or the mask register. Writes to the cause register clear every bit written as one. Reads return data combinationally from the current state. The flag bit positions are fixed, because the driver decodes them:

| Bit | Flag |
|---|---|
| 0 | transfer done |
| 1 | transfer ready |
| 2 | read FIFO ready |
| 3 | write FIFO ready |
| 4 | read FIFO empty |
| 5 | read FIFO full |
| 6 | write FIFO empty |
| 7 | write FIFO full |
| 8 | read FIFO underflow |
| 9 | read FIFO overflow |
| 10 | write FIFO underflow |
| 11 | write FIFO overflow |
| 12 | address not configured |

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, every cause bit, every mask bit and the interrupt output are zero.
- R2: Select 0 reads the flag vector sampled at the previous clock edge, whatever the cause and mask contents. The bit map is the one in the table above.
- R3: A cause bit sets at the clock edge where its flag is high and was low at the edge before. A flag that stays high does not set the bit again after it has been cleared.
- R4: A write to select 1 clears each cause bit whose write-data bit is one. Bits written as zero keep their value.
- R5: The interrupt output is registered. It goes high one clock after a cause bit and its mask bit are both set. It stays low while the mask is zero.
- R6: A write to select 2 loads the mask from the write data, and select 2 reads the mask back.
- R7: When a rising edge and a clearing write hit the same cause bit at the same clock edge, the bit ends up set.
- R8: Writes to select 0 and select 3 change neither cause nor mask, and select 3 reads zero.
- R9: A flag that went high and had its cause cleared before its mask bit was enabled never drives the interrupt output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flagsIn | input | 13 | Live condition flags, bit map as in R2 |
| regAddr | input | 2 | Register select: 0 status, 1 cause, 2 mask, 3 unused |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 13 | Write data |
| regRdData | output | 13 | Read data of the selected register |
| irqOut | output | 1 | Interrupt request, registered |

## Verification
The hardest case to reach is a flag rising in exactly the cycle in which software writes a one to clear the same cause bit. The stimulus holds that flag low, then drives the rising flag and the clearing write in the same cycle. It then reads the cause register to confirm the set took priority.

The already-high-before-unmask case also needs a set sequence. The flag is raised while the mask is zero, the resulting cause is cleared, and only then is the mask opened, so that the interrupt line is watched with a stale high flag present.

A behavioural per-cycle model then follows several hundred cycles of random flags and writes, to cover the remaining combinations.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  // Register select codes; the driver depends on these values.
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_SPARE  = 2'd3
  } regSel_e;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic causeClr;
    logic maskLoad;
  } irqStrobe_t;

endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int NUM_FLAGS = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  output irqStrobe_t           strobes,
  output logic [NUM_FLAGS-1:0] riseVec,
  output logic [NUM_FLAGS-1:0] statusVec
);

  logic [NUM_FLAGS-1:0] flagPrev;
  regSel_e              sel;

  assign sel = regSel_e'(regAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagPrev <= '0;
    else       flagPrev <= flagsIn;
  end

  // One edge detector per flag.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_edge
    assign riseVec[i] = flagsIn[i] & ~flagPrev[i];
  end

  assign statusVec = flagPrev;

  always_comb begin
    strobes          = '0;
    strobes.causeClr = regWrEn && (sel == SEL_CAUSE);
    strobes.maskLoad = regWrEn && (sel == SEL_MASK);
  end

  // R2
  status_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (statusVec == $past(flagsIn)));

endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int NUM_FLAGS = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqStrobe_t           strobes,
  input  logic [NUM_FLAGS-1:0] riseVec,
  input  logic [NUM_FLAGS-1:0] statusVec,
  input  logic [1:0]           regAddr,
  input  logic [NUM_FLAGS-1:0] wrData,
  output logic [NUM_FLAGS-1:0] rdData,
  output logic                 irqOut
);

  logic [NUM_FLAGS-1:0] cause;
  logic [NUM_FLAGS-1:0] causeNext;
  logic [NUM_FLAGS-1:0] mask;

  // A rising edge takes priority over a clearing write to the same bit.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cause
    assign causeNext[i] = riseVec[i] | (cause[i] & ~(strobes.causeClr & wrData[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cause  <= '0;
      mask   <= '0;
      irqOut <= 1'b0;
    end else begin
      cause  <= causeNext;
      irqOut <= |(cause & mask);
      if (strobes.maskLoad) mask <= wrData;
    end
  end

  always_comb begin
    unique case (regSel_e'(regAddr))
      SEL_STATUS: rdData = statusVec;
      SEL_CAUSE:  rdData = cause;
      SEL_MASK:   rdData = mask;
      default:    rdData = '0;
    endcase
  end

  // R3
  cause_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec == '0) |=> ((cause & ~$past(cause)) == '0));

  // R4
  clear_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.causeClr |=> ((cause & $past(wrData & ~riseVec)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.causeClr && ((riseVec & wrData) != '0))
      |=> ((cause & $past(riseVec & wrData)) == $past(riseVec & wrData)));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '0) |=> !irqOut);

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int NUM_FLAGS = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [NUM_FLAGS-1:0] regWrData,
  output logic [NUM_FLAGS-1:0] regRdData,
  output logic                 irqOut
);

  irqStrobe_t           strobes;
  logic [NUM_FLAGS-1:0] riseVec;
  logic [NUM_FLAGS-1:0] statusVec;

  spi_irq_ctrl #(.NUM_FLAGS(NUM_FLAGS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .flagsIn   (flagsIn),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .strobes   (strobes),
    .riseVec   (riseVec),
    .statusVec (statusVec)
  );

  spi_irq_datapath #(.NUM_FLAGS(NUM_FLAGS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .riseVec   (riseVec),
    .statusVec (statusVec),
    .regAddr   (regAddr),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/spi_irq_unit_tb.sv
`timescale 1ns/1ps
module spi_irq_unit_tb_top;

  localparam int N = 13;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] flagsDrv = '0;
  logic [1:0]   addrDrv = 2'd0;
  logic         wrEnDrv = 1'b0;
  logic [N-1:0] wdataDrv = '0;
  logic [N-1:0] rdData;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  spi_irq_unit #(.NUM_FLAGS(N)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .flagsIn   (flagsDrv),
    .regAddr   (addrDrv),
    .regWrEn   (wrEnDrv),
    .regWrData (wdataDrv),
    .regRdData (rdData),
    .irqOut    (irq)
  );

  // Behavioural reference model, updated once per clock.
  logic [N-1:0] mCause, mMask, mPrev;
  logic         mIrq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCause = '0; mMask = '0; mPrev = '0; mIrq = 1'b0;
    end else begin
      logic anyHit;
      anyHit = 1'b0;
      for (int i = 0; i < N; i++) if (mCause[i] && mMask[i]) anyHit = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (flagsDrv[i] && !mPrev[i]) mCause[i] = 1'b1;
        else if (wrEnDrv && addrDrv == 2'd1 && wdataDrv[i]) mCause[i] = 1'b0;
      end
      if (wrEnDrv && addrDrv == 2'd2) mMask = wdataDrv;
      mPrev = flagsDrv;
      mIrq  = anyHit;
    end
  end

  function automatic logic [N-1:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return mPrev;
      2'd1:    return mCause;
      2'd2:    return mMask;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    string tag;
    case (addrDrv)
      2'd0:    tag = "R2 model status";
      2'd1:    tag = "R3 model cause";
      2'd2:    tag = "R6 model mask";
      default: tag = "R8 model spare";
    endcase
    check(tag, 32'(rdData), 32'(expRead(addrDrv)));
    check("R5 model irq", 32'(irq), 32'(mIrq));
  endtask

  task automatic step(input logic [N-1:0] f, input logic we, input logic [1:0] a,
                      input logic [N-1:0] d);
    @(negedge clk);
    compareModel();
    flagsDrv = f; wrEnDrv = we; addrDrv = a; wdataDrv = d;
    #1;
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    step('0, 0, 2'd1, '0);
    check("R1 cause after reset", 32'(rdData), 0);
    check("R1 irq after reset", 32'(irq), 0);
    step('0, 0, 2'd2, '0);
    check("R1 mask after reset", 32'(rdData), 0);

    step('0, 1, 2'd2, ALL);
    step('0, 0, 2'd2, '0);
    check("R6 mask readback", 32'(rdData), 32'h1FFF);

    // transfer-done flag rises
    step(13'h0001, 0, 2'd1, '0);
    step(13'h0001, 0, 2'd1, '0);
    check("R3 cause set on rise", 32'(rdData), 32'h1);
    check("R5 irq one cycle later, not yet", 32'(irq), 0);
    step(13'h0001, 0, 2'd1, '0);
    check("R5 irq high", 32'(irq), 1);

    step(13'h0001, 1, 2'd1, 13'h0001);
    step(13'h0001, 0, 2'd1, '0);
    check("R4 cause cleared", 32'(rdData), 0);
    for (int k = 0; k < 3; k++) step(13'h0001, 0, 2'd1, '0);
    check("R3 held flag does not re-set", 32'(rdData), 0);
    check("R3 irq low after clear", 32'(irq), 0);

    // read-FIFO full rises, then a write of zeros
    step(13'h0021, 0, 2'd1, '0);
    step(13'h0021, 1, 2'd1, '0);
    step(13'h0021, 0, 2'd1, '0);
    check("R4 zero write keeps bits", 32'(rdData), 32'h20);
    step(13'h0021, 1, 2'd1, ALL);
    step(13'h0021, 0, 2'd1, '0);
    check("R4 clear all", 32'(rdData), 0);

    // rising edge and clear of the same bit in one cycle
    step(13'h0025, 1, 2'd1, 13'h0004);
    step(13'h0025, 0, 2'd1, '0);
    check("R7 set wins over clear", 32'(rdData), 32'h4);

    step(13'h0025, 1, 2'd1, ALL);
    step('0, 1, 2'd2, '0);
    step(13'h0080, 0, 2'd1, '0);
    step(13'h0080, 0, 2'd1, '0);
    check("R3 write-FIFO full cause", 32'(rdData), 32'h80);
    step(13'h0080, 0, 2'd1, '0);
    step(13'h0080, 0, 2'd1, '0);
    check("R5 mask zero keeps irq low", 32'(irq), 0);
    step(13'h0080, 1, 2'd2, 13'h0080);
    step(13'h0080, 0, 2'd1, '0);
    check("R5 irq waits one cycle after unmask", 32'(irq), 0);
    step(13'h0080, 0, 2'd1, '0);
    check("R5 irq after unmask", 32'(irq), 1);

    step(13'h0080, 1, 2'd1, ALL);
    step(13'h0080, 1, 2'd2, '0);

    // address-not-configured goes high while masked
    step(13'h1080, 0, 2'd1, '0);
    step(13'h1080, 1, 2'd1, ALL);
    step(13'h1080, 1, 2'd2, ALL);
    step(13'h1080, 0, 2'd0, '0);
    check("R2 status view", 32'(rdData), 32'h1080);
    step(13'h1080, 0, 2'd1, '0);
    step(13'h1080, 0, 2'd1, '0);
    check("R9 stale flag gives no irq", 32'(irq), 0);
    check("R9 stale flag gives no cause", 32'(rdData), 0);

    step(13'h1080, 1, 2'd0, ALL);
    step(13'h1080, 1, 2'd3, ALL);
    step(13'h1080, 0, 2'd3, '0);
    check("R8 spare reads zero", 32'(rdData), 0);
    step(13'h1080, 0, 2'd1, '0);
    check("R8 cause untouched", 32'(rdData), 0);
    step(13'h1080, 0, 2'd2, '0);
    check("R8 mask untouched", 32'(rdData), 32'h1FFF);

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] f, d;
      f = N'($urandom);
      d = N'($urandom);
      step(f, 1'($urandom_range(0, 2) == 0), 2'($urandom), d);
    end
    @(negedge clk);
    compareModel();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule